// File: doc/BRIEF.md
# Pretrigger/Posttrigger Acquisition Sequencer

This block runs one waveform acquisition cycle for a sampling front end that has two sample paths. One is a fast direct stream, used when sampling is fast and conversion is slow. The other is a slow-path stream of samples entering a shift register. A host programs the block through a small register port. The port has an active-low select, a 3-bit address, write and read strobes, and a bidirectional data bus. Through it the host sets the mode, the pretrigger sample count and the post-trigger sample count, and then issues a start command.

After a start, the block counts strobes on the stream that the mode selects. While that count is below the pretrigger requirement, the trigger input has no effect. Once enough samples are held, the trigger is armed. The first trigger then moves the block into the post-trigger phase. In that phase it counts exactly the programmed number of samples, then stops and reports done. The mode outputs (fast path, roll, envelope) are captured from the control register when a start is accepted. They then stay fixed until the next start.

Top module: `acq_sequencer`

## Requirements
- R1: The registers react to the write and read strobes only while `cs_n` is low. A write with `cs_n` high changes nothing.
- R2: Register map, selected by the 3-bit address:
  - Address 0 is the control register. Bit 0 selects the fast-in stream (1) or the slow-path stream (0). Bit 1 is roll and bit 2 is envelope.
  - Address 1 holds the pretrigger count and address 2 the post-trigger count. Both sit in the low CW bits.
  - Address 3 is the command register. Writing it with bit 0 set is a start.
  - Address 4 is the status register. Bits [2:0] hold the state code and bit 3 the done flag.
  - Addresses 0, 1 and 2 read back what was written. Other addresses read as zero.
- R3: The block drives `host_data` only while `cs_n` is low and `rd_en` is high. At other times the host can drive the bus for writes.
- R4: The state codes are IDLE=0, PRETRIG_FILL=1, ARMED=2, POSTTRIG=3 and DONE=4. `trig_arm_o` rises one cycle after the selected stream has delivered the programmed pretrigger count. It rises one cycle after the start when that count is zero.
- R5: A trigger that arrives during PRETRIG_FILL is dropped and is not remembered. Strobes on the unselected stream are never counted.
- R6: The block counts exactly the post-trigger number of selected samples after the trigger. One cycle later it enters DONE, and `acq_done_o` goes high.
- R7: `fast_mode_o`, `roll_o` and `env_o` take the control register value when a start is accepted. They hold that value while the control register is rewritten during the cycle.
- R8: A start is accepted only in IDLE or DONE. An accepted start clears the counters and the done flag. A start written in any other state has no effect.
- R9: The done flag is set on entry to DONE. A read of the status register returns the flag and clears it.
- R10: `smp_store_o` pulses for each selected sample in PRETRIG_FILL and ARMED. It also pulses for each of the first post-trigger samples in POSTTRIG. It never pulses in IDLE or DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low register select |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| host_data | inout | DW | Bidirectional host data bus |
| fast_smp | input | 1 | Fast-in direct sample strobe |
| slow_smp | input | 1 | Slow-path register sample strobe |
| trig_in | input | 1 | Trigger event |
| trig_arm_o | output | 1 | Trigger armed (state ARMED) |
| acq_done_o | output | 1 | Acquisition complete (state DONE) |
| smp_store_o | output | 1 | Current sample is kept |
| fast_mode_o | output | 1 | Latched fast-path mode |
| roll_o | output | 1 | Latched roll mode |
| env_o | output | 1 | Latched envelope mode |

## Verification
The bench builds the block with DW=8 and CW=4, so both counts range over 0 to 15. With these values it sweeps every pretrigger and post-trigger count from 0 to 7 in both modes. That sweep covers the zero-count paths, and the arming and done edges at every small count. At each step it checks the cycle-exact arm and done timing. It also checks the number of stored samples, that early triggers and wrong-stream strobes are dropped, and that the mode outputs stay fixed across register rewrites.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_PRETRIG  = 3'd1,
    S_ARMED    = 3'd2,
    S_POSTTRIG = 3'd3,
    S_DONE     = 3'd4
  } acq_state_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PRE  = 3'd1;
  localparam logic [2:0] A_POST = 3'd2;
  localparam logic [2:0] A_CMD  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  typedef struct packed {
    logic env;
    logic roll;
    logic fast;
  } mode_t;
endpackage

// File: rtl/acq_host_regs.sv
module acq_host_regs
  import acq_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_oe,
  input  acq_state_e    cur_state,
  input  logic          done_flag,
  output mode_t         ctl,
  output logic [CW-1:0] pre_req,
  output logic [CW-1:0] post_req,
  output logic          start_p,
  output logic          stat_rd_p
);
  logic wr_hit;
  logic ctl_we, pre_we, post_we;

  assign wr_hit    = !cs_n && wr_en;
  assign ctl_we    = wr_hit && (addr == A_CTRL);
  assign pre_we    = wr_hit && (addr == A_PRE);
  assign post_we   = wr_hit && (addr == A_POST);
  assign start_p   = wr_hit && (addr == A_CMD) && wdata[0];
  assign rd_oe     = !cs_n && rd_en;
  assign stat_rd_p = rd_oe && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      pre_req  <= '0;
      post_req <= '0;
    end else begin
      if (ctl_we)  ctl      <= mode_t'(wdata[2:0]);
      if (pre_we)  pre_req  <= wdata[CW-1:0];
      if (post_we) post_req <= wdata[CW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:  rdata[2:0]    = ctl;
      A_PRE:   rdata[CW-1:0] = pre_req;
      A_POST:  rdata[CW-1:0] = post_req;
      A_STAT:  rdata[3:0]    = {done_flag, cur_state};
      default: rdata         = '0;
    endcase
  end

  // R1
  no_write_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(pre_req) && $stable(post_req) && $stable(ctl));
endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import acq_seq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_p,
  input  logic          stat_rd_p,
  input  logic          sel_smp,
  input  logic          trig_in,
  input  logic [CW-1:0] pre_req,
  input  logic [CW-1:0] post_req,
  output acq_state_e    state,
  output logic          done_flag,
  output logic          start_acc,
  output logic          store_o
);
  acq_state_e    state_nxt;
  logic [CW-1:0] pre_cnt, post_cnt;
  logic          pre_met, post_met;
  logic          pre_inc, post_inc;

  assign pre_met   = (pre_cnt == pre_req);
  assign post_met  = (post_cnt == post_req);
  assign start_acc = start_p && (state == S_IDLE || state == S_DONE);
  assign pre_inc   = (state == S_PRETRIG) && sel_smp && !pre_met;
  assign post_inc  = (state == S_POSTTRIG) && sel_smp && !post_met;
  assign store_o   = sel_smp && ((state == S_PRETRIG) || (state == S_ARMED) ||
                                 ((state == S_POSTTRIG) && !post_met));

  always_comb begin
    state_nxt = state;
    unique case (state)
      S_IDLE:     if (start_acc) state_nxt = S_PRETRIG;
      S_PRETRIG:  if (pre_met)   state_nxt = S_ARMED;
      S_ARMED:    if (trig_in)   state_nxt = S_POSTTRIG;
      S_POSTTRIG: if (post_met)  state_nxt = S_DONE;
      S_DONE:     if (start_acc) state_nxt = S_PRETRIG;
      default:                   state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pre_cnt   <= '0;
      post_cnt  <= '0;
      done_flag <= 1'b0;
    end else begin
      state <= state_nxt;
      if (start_acc)    pre_cnt <= '0;
      else if (pre_inc) pre_cnt <= pre_cnt + 1'b1;
      if (start_acc || (state == S_ARMED)) post_cnt <= '0;
      else if (post_inc)                   post_cnt <= post_cnt + 1'b1;
      if (start_acc)
        done_flag <= 1'b0;
      else if (state == S_POSTTRIG && post_met)
        done_flag <= 1'b1;
      else if (stat_rd_p)
        done_flag <= 1'b0;
    end
  end

  // R4
  no_early_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRETRIG && !pre_met) |=> (state != S_ARMED));
  // R5
  no_trig_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRETRIG) |=> (state != S_POSTTRIG));
  // R6
  exact_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_DONE) |-> ($past(post_cnt) == post_req));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POSTTRIG) |-> (post_cnt <= post_req));
  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && state == S_ARMED && !trig_in) |=> (state == S_ARMED));
  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_DONE) |-> done_flag);
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          cs_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  inout  wire  [DW-1:0] host_data,
  input  logic          fast_smp,
  input  logic          slow_smp,
  input  logic          trig_in,
  output logic          trig_arm_o,
  output logic          acq_done_o,
  output logic          smp_store_o,
  output logic          fast_mode_o,
  output logic          roll_o,
  output logic          env_o
);
  logic          rst_s1, rst_n;
  logic [DW-1:0] rdata;
  logic          rd_oe;
  acq_state_e    state;
  logic          done_flag, start_p, stat_rd_p, start_acc, sel_smp;
  mode_t         ctl, mode_q;
  logic [CW-1:0] pre_req, post_req;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_s1 <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_n  <= rst_s1;
    end
  end

  assign host_data = rd_oe ? rdata : {DW{1'bz}};

  acq_host_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(host_data), .rdata(rdata), .rd_oe(rd_oe),
    .cur_state(state), .done_flag(done_flag), .ctl(ctl),
    .pre_req(pre_req), .post_req(post_req), .start_p(start_p),
    .stat_rd_p(stat_rd_p)
  );

  assign sel_smp = mode_q.fast ? fast_smp : slow_smp;

  acq_seq_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .stat_rd_p(stat_rd_p),
    .sel_smp(sel_smp), .trig_in(trig_in), .pre_req(pre_req),
    .post_req(post_req), .state(state), .done_flag(done_flag),
    .start_acc(start_acc), .store_o(smp_store_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= '0;
    else if (start_acc) mode_q <= ctl;
  end

  assign fast_mode_o = mode_q.fast;
  assign roll_o      = mode_q.roll;
  assign env_o       = mode_q.env;
  assign trig_arm_o  = (state == S_ARMED);
  assign acq_done_o  = (state == S_DONE);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc |=> $stable(mode_q));
  // R10
  no_store_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_DONE) |-> !smp_store_o);
endmodule

// File: tb/acq_sequencer_tb.sv
module acq_sequencer_tb;
  localparam int DW = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic cs_n = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic tb_oe = 1'b0;
  logic [DW-1:0] tb_do = '0;
  wire  [DW-1:0] host_data;
  logic fast_smp = 1'b0, slow_smp = 1'b0, trig_in = 1'b0;
  logic trig_arm_o, acq_done_o, smp_store_o, fast_mode_o, roll_o, env_o;

  int n_chk = 0, n_bad = 0, n_store = 0;
  logic finished = 1'b0;

  assign host_data = tb_oe ? tb_do : {DW{1'bz}};

  always #2 clk = ~clk;

  acq_sequencer #(.DW(DW), .CW(CW)) u_dut (
    .clk(clk), .arst_n(arst_n), .cs_n(cs_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .host_data(host_data), .fast_smp(fast_smp),
    .slow_smp(slow_smp), .trig_in(trig_in), .trig_arm_o(trig_arm_o),
    .acq_done_o(acq_done_o), .smp_store_o(smp_store_o),
    .fast_mode_o(fast_mode_o), .roll_o(roll_o), .env_o(env_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs_n = !sel; addr = a; wr_en = 1'b1; tb_oe = 1'b1; tb_do = d;
    @(negedge clk);
    cs_n = 1'b1; wr_en = 1'b0; tb_oe = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_en = 1'b1;
    #1 d = host_data;
    @(negedge clk);
    cs_n = 1'b1; rd_en = 1'b0;
  endtask

  // one cycle of stream/trigger stimulus; kind 0 idle, 1 selected, 2 other, 3 trigger
  task automatic pulse(input int kind, input logic mode);
    @(negedge clk);
    if (kind == 1) begin if (mode) fast_smp = 1'b1; else slow_smp = 1'b1; end
    if (kind == 2) begin if (mode) slow_smp = 1'b1; else fast_smp = 1'b1; end
    if (kind == 3) trig_in = 1'b1;
    #1 if (smp_store_o) n_store++;
    @(negedge clk);
    fast_smp = 1'b0; slow_smp = 1'b0; trig_in = 1'b0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rv;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_reg(3'd4, rv);
    chk("R4 reset status", int'(rv), 0);
    chk("R6 reset done", int'(acq_done_o), 0);
    chk("R7 reset mode", int'({env_o, roll_o, fast_mode_o}), 0);

    // R1 / R2 / R3 readback and unselected write
    wr_reg(3'd1, 8'h09);
    wr_reg(3'd1, 8'h05, 1'b0);
    rd_reg(3'd1, rv);
    chk("R1 unselected write", int'(rv), 9);
    wr_reg(3'd2, 8'h0C);
    rd_reg(3'd2, rv);
    chk("R2 post readback", int'(rv), 12);
    wr_reg(3'd0, 8'h05);
    rd_reg(3'd0, rv);
    chk("R3 ctl readback", int'(rv), 5);
    rd_reg(3'd6, rv);
    chk("R2 unused addr", int'(rv), 0);

    for (int m = 0; m < 2; m++) begin
      for (int pre = 0; pre < 8; pre++) begin
        for (int post = 0; post < 8; post++) begin
          logic [2:0] c;
          c = {logic'(post % 2), logic'(pre % 2), logic'(m)};
          wr_reg(3'd0, {5'b0, c});
          wr_reg(3'd1, DW'(pre));
          wr_reg(3'd2, DW'(post));
          n_store = 0;
          wr_reg(3'd3, 8'h01);
          chk("R7 latched", int'({env_o, roll_o, fast_mode_o}), int'(c));
          for (int k = 0; k < pre; k++) begin
            chk("R4 not armed", int'(trig_arm_o), 0);
            pulse(3, logic'(m));
            pulse(2, logic'(m));
            pulse(1, logic'(m));
          end
          chk("R4 arm edge low", int'(trig_arm_o), 0);
          pulse(0, logic'(m));
          chk("R4 armed", int'(trig_arm_o), 1);
          rd_reg(3'd4, rv);
          chk("R5 early trig dropped", int'(rv), 2);
          wr_reg(3'd3, 8'h01);
          rd_reg(3'd4, rv);
          chk("R8 busy start ignored", int'(rv), 2);
          wr_reg(3'd0, {5'b0, ~c});
          chk("R7 held", int'({env_o, roll_o, fast_mode_o}), int'(c));
          pulse(1, logic'(m));
          pulse(3, logic'(m));
          for (int k = 0; k < post; k++) begin
            chk("R6 not done", int'(acq_done_o), 0);
            pulse(2, logic'(m));
            pulse(1, logic'(m));
          end
          chk("R6 done edge low", int'(acq_done_o), 0);
          pulse(0, logic'(m));
          chk("R6 done", int'(acq_done_o), 1);
          pulse(1, logic'(m));
          chk("R10 store count", n_store, pre + 1 + post);
          rd_reg(3'd4, rv);
          chk("R9 status done", int'(rv), 12);
          rd_reg(3'd4, rv);
          chk("R9 flag cleared", int'(rv), 4);
        end
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule